// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Wildcard Fields

This block decides, once per second, whether the clock has reached the programmed alarm time. On each update strobe it compares the new seconds, minutes and hours bytes with three alarm bytes, one per field. If every field matches and alarms are enabled, it sets a sticky alarm flag. An interrupt request is driven while the flag is set and the enable is high.

An alarm byte whose two top bits are both 1 (any value from 0xC0 to 0xFF) is a wildcard and matches every value of its field. The choice of wildcard fields sets the alarm period:
- explicit values in all three bytes give one alarm per day;
- a wildcard hours byte gives one alarm per hour;
- wildcard hours and minutes give one alarm per minute;
- wildcards in all three give an alarm every second.

The comparison is a plain byte comparison, so it works the same way for binary and BCD data. In 12-hour operation bit 7 of the hours byte is the PM marker and takes part in the comparison like any other bit. The host clears the flag with a read strobe. Register decoding and the timekeeping counters sit outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` and `alarm_irq` are both 0.
- R2: When `upd_stb` is high, `alarm_en` is high and all three time bytes equal their alarm bytes, `alarm_flag` is 1 from the next clock edge.
- R3: An update in which any field's alarm byte is not a wildcard and differs from its time byte does not set `alarm_flag`.
- R4: An alarm byte with bits 7 and 6 both set (0xC0 to 0xFF) matches any time value in that field. This holds for any mix of wildcard and explicit fields, including all three wildcard.
- R5: Alarm bytes 0x80 to 0xBF are not wildcards and are compared exactly. For example, an hours alarm of 0x81 (1 PM in 12-hour form) matches hours 0x81 and not 0x01, and 0xBF does not match 0x3F.
- R6: With `upd_stb` low, matching values never set `alarm_flag`.
- R7: With `alarm_en` low, a matching update does not set `alarm_flag`, and `alarm_irq` stays 0.
- R8: Once set, `alarm_flag` stays 1 through later non-matching updates until `flag_rd` is pulsed.
- R9: `flag_rd` clears `alarm_flag` at the next edge. If a setting update occurs in the same cycle, the set wins and the flag stays 1.
- R10: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and `alarm_en` is 1. Dropping `alarm_en` masks the request without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_stb | input | 1 | One-cycle pulse; time bytes hold the newly updated time |
| alarm_en | input | 1 | Alarm interrupt enable |
| flag_rd | input | 1 | Host read of the flag register; clears the flag |
| tm_sec | input | 8 | Current seconds byte |
| tm_min | input | 8 | Current minutes byte |
| tm_hr | input | 8 | Current hours byte (bit 7 = PM in 12-hour form) |
| al_sec | input | 8 | Seconds alarm byte |
| al_min | input | 8 | Minutes alarm byte |
| al_hr | input | 8 | Hours alarm byte |
| alarm_flag | output | 1 | Sticky alarm status |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The match is driven with exact times that agree in all three fields, and with times that differ in only one field at a time. This shows that each field is compared on its own. Wildcards are placed in the hours field only, in hours and minutes, in all three fields, and in the seconds field alone. This separates a true top-two-bit wildcard test from a check of bit 7 only. Values 0x81 and 0xBF separate a PM hour from its AM twin and from a wildcard. Further sequences cover:
- a strobe that is missing;
- an enable that is low;
- read and set in the same cycle;
- an enable dropped after the flag is set.

Together these show that gating, stickiness and the priority of set over clear are handled in the flag logic and not in the comparison.

// File: rtl/rtc_alm_pkg.sv
// Package: rtc_alm_pkg
// Shared constants and the field index type for the alarm comparator.
// Assumes byte-wide time fields and a two-bit wildcard prefix.
package rtc_alm_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WC_W    = 2;
    localparam int unsigned NFIELD  = 3;

    typedef enum logic [1:0] {
        FLD_SEC = 2'd0,
        FLD_MIN = 2'd1,
        FLD_HR  = 2'd2
    } fld_e;
endpackage

// File: rtl/rtc_alm_field.sv
// Module: rtc_alm_field
// Compares one time byte with its alarm byte. An alarm byte whose top
// WC_W bits are all ones is a wildcard and always hits. The comparison
// is raw, so binary and BCD data, and the 12-hour PM bit, need no
// special handling. Purely combinational.
module rtc_alm_field #(
    parameter int unsigned W    = 8,
    parameter int unsigned WC_W = 2
) (
    input  logic [W-1:0] tm_byte,
    input  logic [W-1:0] al_byte,
    output logic         hit
);
    logic wild;

    // Detect a wildcard code and form the per-field hit.
    always_comb begin
        wild = &al_byte[W-1 -: WC_W];
        hit  = wild || (tm_byte == al_byte);
    end
endmodule

// File: rtl/rtc_alm_flag.sv
// Module: rtc_alm_flag
// Sticky alarm flag. A set request wins over a clear request in the
// same cycle. The interrupt request is the flag gated by the enable.
// Assumes a synchronous active-low reset.
module rtc_alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic en,
    output logic flag,
    output logic irq
);
    // Hold, set or clear the sticky status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Gate the status into an interrupt request.
    always_comb begin
        irq = flag && en;
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Module: rtc_alarm_match
// Alarm comparator for a real-time clock. On each update strobe, the new
// seconds, minutes and hours bytes are checked against three alarm
// bytes. Each alarm byte can be a wildcard. A full match with the enable
// high sets a sticky flag, which the host clears by a read strobe.
// Assumes the time bytes are valid in the cycle the strobe is high.
module rtc_alarm_match
    import rtc_alm_pkg::*;
#(
    parameter int unsigned W  = BYTE_W,
    parameter int unsigned WC = WC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_stb,
    input  logic         alarm_en,
    input  logic         flag_rd,
    input  logic [W-1:0] tm_sec,
    input  logic [W-1:0] tm_min,
    input  logic [W-1:0] tm_hr,
    input  logic [W-1:0] al_sec,
    input  logic [W-1:0] al_min,
    input  logic [W-1:0] al_hr,
    output logic         alarm_flag,
    output logic         alarm_irq
);
    localparam int unsigned NF = NFIELD;

    logic [NF-1:0][W-1:0] tm_v;
    logic [NF-1:0][W-1:0] al_v;
    logic [NF-1:0]        fld_hit;
    logic                 all_hit;
    logic                 set_req;

    // Gather the fields into indexed vectors.
    always_comb begin
        tm_v[FLD_SEC] = tm_sec;
        tm_v[FLD_MIN] = tm_min;
        tm_v[FLD_HR]  = tm_hr;
        al_v[FLD_SEC] = al_sec;
        al_v[FLD_MIN] = al_min;
        al_v[FLD_HR]  = al_hr;
    end

    for (genvar g = 0; g < NF; g++) begin : g_fld
        rtc_alm_field #(.W(W), .WC_W(WC)) u_fld (
            .tm_byte (tm_v[g]),
            .al_byte (al_v[g]),
            .hit     (fld_hit[g])
        );
    end

    // Combine the field hits with the strobe and the enable.
    always_comb begin
        all_hit = &fld_hit;
        set_req = upd_stb && alarm_en && all_hit;
    end

    rtc_alm_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_req),
        .clr_req (flag_rd),
        .en      (alarm_en),
        .flag    (alarm_flag),
        .irq     (alarm_irq)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
// Module: rtc_alarm_match_chk
// Temporal checks on the comparator's ports, bound to every instance.
module rtc_alarm_match_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         upd_stb,
    input logic         alarm_en,
    input logic         flag_rd,
    input logic [W-1:0] tm_sec,
    input logic [W-1:0] tm_min,
    input logic [W-1:0] tm_hr,
    input logic [W-1:0] al_sec,
    input logic [W-1:0] al_min,
    input logic [W-1:0] al_hr,
    input logic         alarm_flag,
    input logic         alarm_irq
);
    // R2: an exact match on an enabled update sets the flag.
    p_exact_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_stb && alarm_en && tm_sec == al_sec && tm_min == al_min && tm_hr == al_hr)
        |=> alarm_flag);

    // R3: an explicit seconds mismatch cannot raise a clear flag.
    p_sec_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && al_sec[W-1:W-2] != 2'b11 && tm_sec != al_sec)
        |=> !alarm_flag);

    // R6: without a strobe the flag cannot rise.
    p_no_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !upd_stb) |=> !alarm_flag);

    // R7: without the enable the flag cannot rise.
    p_no_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_flag && !alarm_en) |=> !alarm_flag);

    // R8: the flag holds until a read.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_rd) |=> alarm_flag);

    // R9: a read with no strobe clears the flag.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !upd_stb) |=> !alarm_flag);

    // R10: the request needs both the flag and the enable.
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_flag && alarm_en));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_stb    (upd_stb),
    .alarm_en   (alarm_en),
    .flag_rd    (flag_rd),
    .tm_sec     (tm_sec),
    .tm_min     (tm_min),
    .tm_hr      (tm_hr),
    .al_sec     (al_sec),
    .al_min     (al_min),
    .al_hr      (al_hr),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/rtc_alarm_match_tb_top.sv
// Directed bench for rtc_alarm_match: one task per scenario.
module rtc_alarm_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upd_stb = 1'b0;
    logic       alarm_en = 1'b0;
    logic       flag_rd = 1'b0;
    logic [7:0] tm_sec = '0, tm_min = '0, tm_hr = '0;
    logic [7:0] al_sec = '0, al_min = '0, al_hr = '0;
    logic       alarm_flag, alarm_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rtc_alarm_match dut_i (
        .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .alarm_en(alarm_en),
        .flag_rd(flag_rd), .tm_sec(tm_sec), .tm_min(tm_min), .tm_hr(tm_hr),
        .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Present a time and pulse the strobe for one cycle; return on the
    // next falling edge, after the flag register has taken its value.
    task automatic upd(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        tm_hr = h; tm_min = m; tm_sec = s; upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    task automatic alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        al_hr = h; al_min = m; al_sec = s;
    endtask

    task automatic rd_clear();
        @(negedge clk);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flag after reset", alarm_flag, 1'b0);
        chk("R1 irq after reset", alarm_irq, 1'b0);
    endtask

    task automatic t_exact();
        alarm_en = 1'b1;
        alarm(8'h08, 8'h15, 8'h30);
        upd(8'h08, 8'h15, 8'h30);
        chk("R2 exact match flag", alarm_flag, 1'b1);
        chk("R2 exact match irq", alarm_irq, 1'b1);
        rd_clear();
        chk("R9 read clears flag", alarm_flag, 1'b0);
    endtask

    task automatic t_mismatch();
        upd(8'h08, 8'h15, 8'h31);
        chk("R3 seconds differ", alarm_flag, 1'b0);
        upd(8'h08, 8'h16, 8'h30);
        chk("R3 minutes differ", alarm_flag, 1'b0);
        upd(8'h09, 8'h15, 8'h30);
        chk("R3 hours differ", alarm_flag, 1'b0);
    endtask

    task automatic t_wild();
        alarm(8'hC0, 8'h15, 8'h30);
        upd(8'h23, 8'h15, 8'h30);
        chk("R4 hourly wildcard", alarm_flag, 1'b1);
        rd_clear();
        alarm(8'hFF, 8'hD5, 8'h30);
        upd(8'h01, 8'h42, 8'h30);
        chk("R4 per-minute wildcard", alarm_flag, 1'b1);
        rd_clear();
        alarm(8'hE7, 8'hC3, 8'hFE);
        upd(8'h12, 8'h59, 8'h07);
        chk("R4 every-second wildcard", alarm_flag, 1'b1);
        rd_clear();
        alarm(8'h08, 8'h15, 8'hC0);
        upd(8'h08, 8'h15, 8'h59);
        chk("R4 seconds-only wildcard", alarm_flag, 1'b1);
        rd_clear();
    endtask

    task automatic t_pm();
        alarm(8'h81, 8'h00, 8'h00);
        upd(8'h01, 8'h00, 8'h00);
        chk("R5 PM alarm vs AM hour", alarm_flag, 1'b0);
        upd(8'h81, 8'h00, 8'h00);
        chk("R5 PM alarm vs PM hour", alarm_flag, 1'b1);
        rd_clear();
        alarm(8'hBF, 8'h00, 8'h00);
        upd(8'h3F, 8'h00, 8'h00);
        chk("R5 0xBF is not wildcard", alarm_flag, 1'b0);
    endtask

    task automatic t_nostb();
        alarm(8'h05, 8'h06, 8'h07);
        @(negedge clk);
        tm_hr = 8'h05; tm_min = 8'h06; tm_sec = 8'h07;
        repeat (3) @(negedge clk);
        chk("R6 match without strobe", alarm_flag, 1'b0);
    endtask

    task automatic t_en();
        alarm_en = 1'b0;
        upd(8'h05, 8'h06, 8'h07);
        chk("R7 disabled match flag", alarm_flag, 1'b0);
        chk("R7 disabled match irq", alarm_irq, 1'b0);
        @(negedge clk);
        alarm_en = 1'b1;
        @(negedge clk);
        chk("R7 enable alone sets nothing", alarm_flag, 1'b0);
    endtask

    task automatic t_sticky();
        upd(8'h05, 8'h06, 8'h07);
        upd(8'h05, 8'h06, 8'h08);
        upd(8'h05, 8'h07, 8'h00);
        upd(8'h06, 8'h00, 8'h00);
        chk("R8 flag sticky", alarm_flag, 1'b1);
    endtask

    task automatic t_rd_set();
        @(negedge clk);
        tm_hr = 8'h05; tm_min = 8'h06; tm_sec = 8'h07;
        upd_stb = 1'b1; flag_rd = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0; flag_rd = 1'b0;
        chk("R9 set wins over read", alarm_flag, 1'b1);
        rd_clear();
        chk("R9 read alone clears", alarm_flag, 1'b0);
    endtask

    task automatic t_irq();
        upd(8'h05, 8'h06, 8'h07);
        @(negedge clk);
        alarm_en = 1'b0;
        #1;
        chk("R10 irq masked", alarm_irq, 1'b0);
        chk("R10 flag kept", alarm_flag, 1'b1);
        alarm_en = 1'b1;
        #1;
        chk("R10 irq restored", alarm_irq, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_mismatch();
        t_wild();
        t_pm();
        t_nostb();
        t_en();
        t_sticky();
        t_rd_set();
        t_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule